// File: doc/BRIEF.md
# Delayed Event Window Matcher

This block is a synchronous protocol monitor. Every clock it samples a request line and an acknowledge line. It treats a sampled rising edge of the request as a trigger. Each trigger opens an attempt that expects an acknowledge response somewhere inside a cycle window `[MIN_DLY, MAX_DLY]` measured from the trigger. A build-time flag selects what counts as a response. It is either a sampled falling edge of the acknowledge or the acknowledge simply being sampled low.

Triggers may arrive on any clock, so several attempts can be pending at once. Each attempt is tracked on its own. An attempt that sees a response at an allowed delay reports a hit tagged with its age and retires. An attempt that reaches the end of the window with no response reports a miss. Delays inside the window are alternatives tried in parallel. A response that comes earlier than `MIN_DLY` never counts.

Top module: `ev_window_mon`

## Requirements
- R1: While `rst_n` is low, the sample registers and the pending-attempt register are cleared, and `hit_age_o` and `miss_o` are all zero.
- R2: A trigger is a sampled `req` of 1 whose previously sampled value was 0. Holding `req` high starts only one attempt.
- R3: With `LEVEL_MODE`=0, a response is a sampled `ack` of 0 whose previous sample was 1.
- R4: With `LEVEL_MODE`=1, a response is any sampled `ack` of 0. With `LEVEL_MODE`=0, an `ack` held low with no falling edge is not a response.
- R5: A response that occurs at a delay below `MIN_DLY` is ignored and does not retire the attempt.
- R6: An attempt whose trigger sample was d clocks before the current sample, with d in the window, raises bit d-1 of `hit_age_o` for one cycle. This happens at the first response in its window, after which the attempt retires and later responses are ignored.
- R7: An attempt that reaches delay `MAX_DLY` without a response raises `miss_o` for one cycle at that delay.
- R8: Attempts from overlapping triggers are independent, and several bits of `hit_age_o` may be set in the same cycle.
- R9: Every delay from `MIN_DLY` through `MAX_DLY`, including `MAX_DLY` itself, is an accepted alternative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request line; its sampled rising edge is the trigger |
| ack | input | 1 | Acknowledge line; its sampled falling edge or low level is the response |
| hit_age_o | output | MAX_DLY | Bit d-1 pulses when the attempt of age d matches |
| miss_o | output | 1 | Pulses when an attempt expires at age MAX_DLY unmatched |

## Verification
The bench drives one stream of request and acknowledge patterns into two instances. One uses edge mode with a window of 2 to 4; the other uses level mode with a window of 1 to 3. A held request separates edge triggering from level triggering. An acknowledge that falls at age 1 and then stays low separates an early response that is discarded from one that is accepted in level mode. A toggling acknowledge with two falling edges shows that an attempt retires after its first hit. Two triggers two cycles apart, answered by a single falling edge, show that overlapping attempts produce simultaneous hits at different ages. A fall exactly at the last allowed delay checks that the upper bound of the window is inclusive.

// File: rtl/evw_pkg.sv
package evw_pkg;
  localparam int unsigned DLY_LIMIT = 8;

  // Window mask: bit i-1 is set when a delay of i lies in [lo, hi].
  function automatic logic [DLY_LIMIT-1:0] win_mask(input int lo, input int hi);
    logic [DLY_LIMIT-1:0] m;
    m = '0;
    for (int i = 1; i <= DLY_LIMIT; i++) begin
      if (i >= lo && i <= hi) m[i-1] = 1'b1;
    end
    return m;
  endfunction

  // Edge-or-level response decision from current and previous ack samples.
  function automatic logic resp_of(input logic level, input logic cur, input logic prev);
    return level ? ~cur : (prev & ~cur);
  endfunction
endpackage

// File: rtl/evw_sampler.sv
module evw_sampler #(
  parameter bit LEVEL_MODE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic ack,
  output logic trig_o,
  output logic resp_o
);
  logic req_q, req_p, ack_q, ack_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      req_p <= 1'b0;
      ack_q <= 1'b0;
      ack_p <= 1'b0;
    end else begin
      req_q <= req;
      req_p <= req_q;
      ack_q <= ack;
      ack_p <= ack_q;
    end
  end

  assign trig_o = req_q & ~req_p;

  generate
    if (LEVEL_MODE) begin : g_level
      assign resp_o = evw_pkg::resp_of(1'b1, ack_q, ack_p);
    end else begin : g_edge
      assign resp_o = evw_pkg::resp_of(1'b0, ack_q, ack_p);
    end
  endgenerate
endmodule

// File: rtl/evw_age_pipe.sv
module evw_age_pipe #(
  parameter int unsigned MAX_DLY = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig_i,
  input  logic [MAX_DLY-1:0] retire_i,
  output logic [MAX_DLY-1:0] age_o
);
  logic [MAX_DLY-1:0] age_q;

  always_ff @(posedge clk) begin
    if (!rst_n) age_q[0] <= 1'b0;
    else        age_q[0] <= trig_i;
  end

  generate
    for (genvar i = 1; i < MAX_DLY; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) age_q[i] <= 1'b0;
        else        age_q[i] <= age_q[i-1] & ~retire_i[i-1];
      end
    end
  endgenerate

  assign age_o = age_q;
endmodule

// File: rtl/evw_judge.sv
module evw_judge #(
  parameter int unsigned MIN_DLY = 2,
  parameter int unsigned MAX_DLY = 4
) (
  input  logic [MAX_DLY-1:0] age_i,
  input  logic               resp_i,
  output logic [MAX_DLY-1:0] hit_o,
  output logic               miss_o
);
  localparam logic [evw_pkg::DLY_LIMIT-1:0] WIN_FULL = evw_pkg::win_mask(MIN_DLY, MAX_DLY);
  localparam logic [MAX_DLY-1:0]            WIN      = WIN_FULL[MAX_DLY-1:0];

  generate
    for (genvar i = 0; i < MAX_DLY; i++) begin : g_slot
      assign hit_o[i] = age_i[i] & WIN[i] & resp_i;
    end
  endgenerate

  assign miss_o = age_i[MAX_DLY-1] & ~resp_i;
endmodule

// File: rtl/ev_window_mon.sv
module ev_window_mon #(
  parameter int unsigned MIN_DLY    = 2,
  parameter int unsigned MAX_DLY    = 4,
  parameter bit          LEVEL_MODE = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic               ack,
  output logic [MAX_DLY-1:0] hit_age_o,
  output logic               miss_o
);
  // Named internal events, visible to the bound checker.
  logic               trig;
  logic               resp;
  logic [MAX_DLY-1:0] pend;
  logic [MAX_DLY-1:0] hit;
  logic               miss;

  initial begin
    if (MIN_DLY < 1 || MIN_DLY > MAX_DLY || MAX_DLY > evw_pkg::DLY_LIMIT)
      $error("ev_window_mon: bad window parameters");
  end

  evw_sampler #(.LEVEL_MODE(LEVEL_MODE)) u_samp (
    .clk(clk), .rst_n(rst_n), .req(req), .ack(ack),
    .trig_o(trig), .resp_o(resp)
  );

  evw_age_pipe #(.MAX_DLY(MAX_DLY)) u_pipe (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .retire_i(hit), .age_o(pend)
  );

  evw_judge #(.MIN_DLY(MIN_DLY), .MAX_DLY(MAX_DLY)) u_judge (
    .age_i(pend), .resp_i(resp), .hit_o(hit), .miss_o(miss)
  );

  assign hit_age_o = hit;
  assign miss_o    = miss;
endmodule

// File: rtl/ev_window_chk.sv
module ev_window_chk #(
  parameter int unsigned MIN_DLY = 2,
  parameter int unsigned MAX_DLY = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               trig,
  input logic [MAX_DLY-1:0] pend,
  input logic [MAX_DLY-1:0] hit_age_o,
  input logic               miss_o
);
  localparam logic [evw_pkg::DLY_LIMIT-1:0] WF = evw_pkg::win_mask(MIN_DLY, MAX_DLY);
  localparam logic [MAX_DLY-1:0]            WM = WF[MAX_DLY-1:0];

  // R5
  early_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_age_o & ~WM) == '0);

  // R7
  miss_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_o |-> $past(trig, MAX_DLY));

  // R2
  trig_enqueue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> pend[0]);

  generate
    for (genvar d = 1; d <= MAX_DLY; d++) begin : g_age
      // R6
      hit_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_age_o[d-1] |-> $past(trig, d));
    end
  endgenerate
endmodule

bind ev_window_mon ev_window_chk #(.MIN_DLY(MIN_DLY), .MAX_DLY(MAX_DLY)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig), .pend(pend),
  .hit_age_o(hit_age_o), .miss_o(miss_o)
);

// File: tb/tb_ev_window_mon.sv
module tb_ev_window_mon;
  typedef struct packed { logic [7:0] hit; logic miss; } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic ack = 1'b1;
  logic [3:0] e_hit;
  logic       e_miss;
  logic [2:0] l_hit;
  logic       l_miss;

  int n_tests = 0;
  int n_fail  = 0;
  int ncyc    = 0;
  string tag  = "R1";
  bit   rq [0:1023];
  bit   ak [0:1023];
  exp_t qe[$];
  exp_t ql[$];

  always #5 clk = ~clk;

  ev_window_mon #(.MIN_DLY(2), .MAX_DLY(4), .LEVEL_MODE(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .ack(ack), .hit_age_o(e_hit), .miss_o(e_miss));
  ev_window_mon #(.MIN_DLY(1), .MAX_DLY(3), .LEVEL_MODE(1'b1)) dut_lvl (
    .clk(clk), .rst_n(rst_n), .req(req), .ack(ack), .hit_age_o(l_hit), .miss_o(l_miss));

  // Reference model from the sampled history, written from the requirements.
  function automatic bit trig_at(int t);
    return rq[t] && (t == 0 ? 1'b1 : !rq[t-1]);
  endfunction

  function automatic bit resp_at(int t, bit lvl);
    if (lvl) return !ak[t];
    return !ak[t] && (t == 0 ? 1'b0 : ak[t-1]);
  endfunction

  function automatic exp_t model(int n, int mn, int mx, bit lvl);
    exp_t r;
    r = '0;
    for (int d = 1; d <= mx; d++) begin
      int t;
      bit done;
      t = n - d;
      done = 1'b0;
      if (t >= 0 && trig_at(t)) begin
        for (int e = mn; e < d; e++) if (resp_at(t + e, lvl)) done = 1'b1;
        if (!done) begin
          if (d >= mn && resp_at(n, lvl)) r.hit[d-1] = 1'b1;
          else if (d == mx) r.miss = 1'b1;
        end
      end
    end
    return r;
  endfunction

  // Driver: applies one sample and pushes the expected results.
  task automatic drive(bit r, bit a);
    @(negedge clk);
    rst_n = 1'b1;
    req = r;
    ack = a;
    rq[ncyc] = r;
    ak[ncyc] = a;
    qe.push_back(model(ncyc, 2, 4, 1'b0));
    ql.push_back(model(ncyc, 1, 3, 1'b1));
    ncyc++;
  endtask

  task automatic run_pat(string t, logic [15:0] rp, logic [15:0] ap, int len);
    tag = t;
    for (int i = 0; i < len; i++) drive(rp[i], ap[i]);
    for (int i = 0; i < 6; i++) drive(1'b0, 1'b1);
  endtask

  // Monitor: pops expected items as the design produces results.
  initial begin
    wait (rst_n === 1'b1);
    forever begin
      @(posedge clk);
      #2;
      if (qe.size() > 0) begin
        exp_t x;
        x = qe.pop_front();
        n_tests++;
        if ({4'b0, e_hit} !== x.hit || e_miss !== x.miss) begin
          n_fail++;
          $display("FAIL %s edge cyc=%0d: hit=%b miss=%b expected hit=%b miss=%b",
                   tag, ncyc, e_hit, e_miss, x.hit[3:0], x.miss);
        end
      end
      if (ql.size() > 0) begin
        exp_t y;
        y = ql.pop_front();
        n_tests++;
        if ({5'b0, l_hit} !== y.hit || l_miss !== y.miss) begin
          n_fail++;
          $display("FAIL %s level cyc=%0d: hit=%b miss=%b expected hit=%b miss=%b",
                   tag, ncyc, l_hit, l_miss, y.hit[2:0], y.miss);
        end
      end
    end
  end

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    req = 1'b1;
    ack = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    // R1: outputs quiet in reset despite a high request
    n_tests++;
    if (e_hit !== 4'b0 || e_miss !== 1'b0 || l_hit !== 3'b0 || l_miss !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: hit=%b/%b miss=%b/%b expected all 0", e_hit, l_hit, e_miss, l_miss);
    end
    @(negedge clk);
    req = 1'b0;
    // First drive releases reset; its sample is history index 0.
    run_pat("R2", 16'h003F, 16'hFFFF, 8);  // held req: single trigger, miss
    run_pat("R3", 16'h0003, 16'h00E7, 8);  // ack falls at age 3
    run_pat("R4", 16'h000C, 16'h0000, 8);  // ack held low: level hit, edge miss
    run_pat("R5", 16'h0001, 16'h00C1, 8);  // ack falls at age 1, below edge MIN
    run_pat("R6", 16'h0001, 16'h00EB, 8);  // two falls: only the first counts
    run_pat("R7", 16'h0001, 16'hFFFF, 8);  // no response at all
    run_pat("R8", 16'h0005, 16'h00CF, 8);  // overlapping triggers
    run_pat("R9", 16'h0001, 16'h00EF, 8);  // fall at the last allowed delay
    repeat (3) @(posedge clk);
    #3;
    n_tests++;
    if (qe.size() != 0 || ql.size() != 0) begin
      n_fail++;
      $display("FAIL R7: %0d/%0d items left, expected 0/0", qe.size(), ql.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule